// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-line general-purpose I/O port on a simple memory-mapped register bus with byte-wide transfers. Each line can be an input or an output. The pins leave the block as a drive value plus an output enable, and pad logic outside the block turns them into tri-state buffers. Input levels pass through a two-flop synchroniser before anything inside the block uses them.

The data window is accessed through the address. Offset bits [9:2] of a data access act as a per-line select. Software can therefore set, clear or sample any subset of pins with one bus transfer and needs no read-modify-write. The direction register has its own offset and reads back what was last written. Interrupt detection, pad multiplexing and the bus bridge lie outside this block.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset every line is an input (`pin_oe` = 0x00), the output data register is 0 (`pin_out` = 0x00), and the direction register reads back 0x00.
- R2: The direction register is at offset 0x400, and offset bits [1:0] are ignored. A write stores `bus_wdata`, and a read returns the stored value. Bit n = 1 makes line n an output, so `pin_oe[n]` equals direction bit n from the edge that samples the write onward.
- R3: A data write uses any offset from 0x000 to 0x3FF, with select = offset bits [9:2]. It sets output data bit n to `bus_wdata[n]` only when select bit n is 1 and line n is an output. `pin_out[n]` always shows output data bit n.
- R4: A data write leaves output data bit n unchanged when line n is an input, even when its select bit is 1. If the line is later switched to output, it drives the value it held before that write.
- R5: A data read returns 0 on every line whose select bit is 0.
- R6: A data read returns the driven output value on a selected output line, whatever level `pin_in` shows on that line.
- R7: A data read returns the synchronised pin level on a selected input line. Let edge k be the first clock edge that samples a new level. A read sampled at edge k or at edge k+1 still returns the old level, and a read sampled at edge k+2 returns the new one.
- R8: `bus_rdata` is registered. It loads at each edge that samples a read (`bus_sel` = 1, `bus_wr` = 0) and holds its value at every other edge.
- R9: A read of any offset outside the data window and the direction register (0x404 to 0xFFF, excluding 0x400 to 0x403) returns 0. A write to such an offset changes neither the direction register nor the output data register.
- R10: A transfer with `bus_sel` = 0 changes no register and does not reload `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Transfer valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the transfer |
| bus_wdata | input | 8 | Write data, one bit per line |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Pin output enables |

## Verification
The masked data path is driven with a pseudo-random mix of select patterns, direction patterns and pin levels. Mixed-direction patterns separate lines that read back the driven value from lines that read back the synchronised pin. Select patterns that cover input lines separate a correct write from one that reaches lines it should not touch. Directed sequences cover the remaining cases:
- a pin change followed by back-to-back reads, which fixes the synchroniser latency to exactly two edges;
- a write to input lines followed by a direction change, which exposes any write that wrongly reached input lines;
- accesses to unmapped offsets and idle cycles, which separate decoded transfers from ignored ones.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   // Kind of register a bus transfer hits
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_DATA = 2'd1,
      ACC_DIR  = 2'd2,
      ACC_VOID = 2'd3
   } acc_kind_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int LINES  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] async_i,
   output logic [LINES-1:0] sync_o
);

   if (STAGES < 0) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign sync_o = async_i;
   end else begin : g_chain
      logic [LINES-1:0] stage_q [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
         end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
         end
      end

      assign sync_o = stage_q[STAGES-1];
   end

endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
   import gpio_port_pkg::*;
#(
   parameter int LINES      = 8,
   parameter int ADDR_W     = 12,
   parameter int MASK_LSB   = 2,
   parameter int DIR_OFFSET = 'h400
) (
   input  logic              sel_i,
   input  logic [ADDR_W-1:0] addr_i,
   output acc_kind_e         kind_o,
   output logic [LINES-1:0]  mask_o
);

   localparam int WIN_BITS = MASK_LSB + LINES;
   localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFFSET);

   if (WIN_BITS >= ADDR_W) begin : g_bad_window
      $error("gpio_addr_decode: data window does not fit below ADDR_W");
   end
   if (DIR_OFFSET < (1 << WIN_BITS) || DIR_OFFSET >= (1 << ADDR_W)) begin : g_bad_dir
      $error("gpio_addr_decode: DIR_OFFSET must lie above the data window");
   end

   logic in_window;
   logic at_dir;
   logic unused_lsbs;

   assign in_window   = (addr_i[ADDR_W-1:WIN_BITS] == '0);
   assign at_dir      = (addr_i[ADDR_W-1:MASK_LSB] == DIR_ADDR[ADDR_W-1:MASK_LSB]);
   assign mask_o      = addr_i[MASK_LSB +: LINES];
   assign unused_lsbs = ^addr_i[MASK_LSB-1:0];

   always_comb begin
      if (!sel_i)         kind_o = ACC_NONE;
      else if (in_window) kind_o = ACC_DATA;
      else if (at_dir)    kind_o = ACC_DIR;
      else                kind_o = ACC_VOID;
   end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
   parameter int LINES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             data_we_i,
   input  logic             dir_we_i,
   input  logic [LINES-1:0] mask_i,
   input  logic [LINES-1:0] wdata_i,
   output logic [LINES-1:0] dir_o,
   output logic [LINES-1:0] out_o
);

   logic [LINES-1:0] dir_q;
   logic [LINES-1:0] out_q;
   logic [LINES-1:0] upd;

   // only selected lines that are already outputs take the new value
   assign upd = data_we_i ? (mask_i & dir_q) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
         out_q <= '0;
      end else begin
         if (dir_we_i) dir_q <= wdata_i;
         out_q <= (out_q & ~upd) | (wdata_i & upd);
      end
   end

   assign dir_o = dir_q;
   assign out_o = out_q;

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
   import gpio_port_pkg::*;
#(
   parameter int LINES       = 8,
   parameter int ADDR_W      = 12,
   parameter int MASK_LSB    = 2,
   parameter int DIR_OFFSET  = 'h400,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [LINES-1:0]  bus_wdata,
   output logic [LINES-1:0]  bus_rdata,
   input  logic [LINES-1:0]  pin_in,
   output logic [LINES-1:0]  pin_out,
   output logic [LINES-1:0]  pin_oe
);

   if (LINES < 1) begin : g_bad_lines
      $error("gpio_mask_port: LINES must be at least 1");
   end
   if (MASK_LSB < 1) begin : g_bad_lsb
      $error("gpio_mask_port: MASK_LSB must be at least 1");
   end

   acc_kind_e        kind;
   logic [LINES-1:0] mask;
   logic [LINES-1:0] dir;
   logic [LINES-1:0] dout;
   logic [LINES-1:0] pin_sync;
   logic [LINES-1:0] rd_next;
   logic [LINES-1:0] rdata_q;

   gpio_addr_decode #(
      .LINES(LINES), .ADDR_W(ADDR_W), .MASK_LSB(MASK_LSB), .DIR_OFFSET(DIR_OFFSET)
   ) dec_i (
      .sel_i(bus_sel), .addr_i(bus_addr), .kind_o(kind), .mask_o(mask)
   );

   gpio_port_regs #(.LINES(LINES)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_we_i(bus_wr && kind == ACC_DATA),
      .dir_we_i (bus_wr && kind == ACC_DIR),
      .mask_i   (mask),
      .wdata_i  (bus_wdata),
      .dir_o    (dir),
      .out_o    (dout)
   );

   gpio_in_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .async_i(pin_in), .sync_o(pin_sync)
   );

   always_comb begin
      unique case (kind)
         ACC_DATA: rd_next = mask & ((dir & dout) | (~dir & pin_sync));
         ACC_DIR:  rd_next = dir;
         default:  rd_next = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  rdata_q <= '0;
      else if (bus_sel && !bus_wr) rdata_q <= rd_next;
   end

   assign bus_rdata = rdata_q;
   assign pin_out   = dout;
   assign pin_oe    = dir;

endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
   parameter int LINES      = 8,
   parameter int ADDR_W     = 12,
   parameter int MASK_LSB   = 2,
   parameter int DIR_OFFSET = 'h400
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [LINES-1:0]  bus_wdata,
   input logic [LINES-1:0]  bus_rdata,
   input logic [LINES-1:0]  pin_out,
   input logic [LINES-1:0]  pin_oe
);

   localparam int WIN_BITS = MASK_LSB + LINES;
   localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFFSET);

   logic             c_data;
   logic             c_dir;
   logic [LINES-1:0] c_sel;
   logic             unused_chk;

   assign c_data     = bus_addr[ADDR_W-1:WIN_BITS] == '0;
   assign c_dir      = bus_addr[ADDR_W-1:MASK_LSB] == DIR_ADDR[ADDR_W-1:MASK_LSB];
   assign c_sel      = bus_addr[MASK_LSB +: LINES];
   assign unused_chk = ^bus_addr[MASK_LSB-1:0];

   always @(negedge clk) begin
      if (!rst_n) begin
         assert_reset_idle_R1: assert (pin_oe == '0 && pin_out == '0);
      end
   end

   assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && c_dir) |=> pin_oe == $past(bus_wdata));

   assert_masked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && c_data) |=>
         ((pin_out ^ $past(bus_wdata)) & $past(c_sel & pin_oe)) == '0);

   assert_input_write_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && c_data) |=>
         ((pin_out ^ $past(pin_out)) & ~$past(c_sel & pin_oe)) == '0);

   assert_unselected_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && c_data) |=> (bus_rdata & ~$past(c_sel)) == '0);

   assert_output_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && c_data) |=>
         ((bus_rdata ^ $past(pin_out)) & $past(c_sel & pin_oe)) == '0);

   assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

   assert_void_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && !c_data && !c_dir) |=> $stable(pin_oe) && $stable(pin_out));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |=> $stable(pin_oe) && $stable(pin_out));

endmodule

bind gpio_mask_port gpio_mask_port_chk #(
   .LINES(LINES), .ADDR_W(ADDR_W), .MASK_LSB(MASK_LSB), .DIR_OFFSET(DIR_OFFSET)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_sel  (bus_sel),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .pin_out  (pin_out),
   .pin_oe   (pin_oe)
);

// File: tb/gpio_mask_port_tb_top.sv
`timescale 1ns/1ps
module gpio_mask_port_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [7:0]  pin_in = '0;
   logic [7:0]  pin_out;
   logic [7:0]  pin_oe;

   int    n_checks = 0;
   int    n_fail = 0;
   string cur_req = "R1";
   logic [15:0] lfsr = 16'hACE1;

   always #4 clk = ~clk;   // 125 MHz

   gpio_mask_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [7:0] m_dir, m_out, m_rd, m_seen, m_sel;
   logic [7:0] pin_hist[$];
   int         off;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_dir = 0; m_out = 0; m_rd = 0;
         pin_hist = {8'h00, 8'h00};
      end else begin
         m_seen = pin_hist[$];          // level captured two edges earlier
         void'(pin_hist.pop_back());
         pin_hist.push_front(pin_in);
         off = int'(bus_addr);
         if (bus_sel) begin
            if (off < 1024) begin
               m_sel = 8'(off / 4);
               if (bus_wr) m_out = (m_out & ~(m_sel & m_dir)) | (bus_wdata & m_sel & m_dir);
               else        m_rd  = m_sel & ((m_dir & m_out) | (~m_dir & m_seen));
            end else if (off / 4 == 256) begin
               if (bus_wr) m_dir = bus_wdata;
               else        m_rd  = m_dir;
            end else if (!bus_wr) begin
               m_rd = 0;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         check("R2 pin_oe vs model", pin_oe, m_dir);
         check("R3 pin_out vs model", pin_out, m_out);
         check({cur_req, " rdata vs model"}, bus_rdata, m_rd);
      end
   end

   // ---------------- stimulus ----------------
   task automatic bus_op(input logic wr, input logic [11:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   function automatic logic [15:0] step(input logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   function automatic logic [11:0] data_addr(input logic [7:0] sel);
      return {2'b00, sel, 2'b00};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset pin_oe", pin_oe, 8'h00);
      check("R1 reset pin_out", pin_out, 8'h00);
      rst_n = 1'b1;
      bus_op(1'b0, 12'h400, 8'h00);
      check("R1 direction after reset", bus_rdata, 8'h00);

      cur_req = "R2";
      bus_op(1'b1, 12'h403, 8'h3C);
      check("R2 oe after dir write (low bits ignored)", pin_oe, 8'h3C);
      bus_op(1'b0, 12'h400, 8'h00);
      check("R2 dir readback", bus_rdata, 8'h3C);

      cur_req = "R4";
      bus_op(1'b1, 12'h400, 8'h00);
      bus_op(1'b1, data_addr(8'hFF), 8'hFF);
      check("R4 write to inputs ignored", pin_out, 8'h00);
      bus_op(1'b1, 12'h400, 8'h0F);
      check("R4 old value after switch", pin_out, 8'h00);

      cur_req = "R3";
      bus_op(1'b1, data_addr(8'hFF), 8'hFF);
      check("R3 output lines written", pin_out, 8'h0F);
      bus_op(1'b1, data_addr(8'h05), 8'h00);
      check("R3 only selected lines cleared", pin_out, 8'h0A);

      cur_req = "R6";
      pin_in = 8'h05;
      repeat (3) @(negedge clk);
      bus_op(1'b0, data_addr(8'hFF), 8'h00);
      check("R6 outputs read driven value", bus_rdata & 8'h0F, 8'h0A);

      cur_req = "R5";
      bus_op(1'b0, data_addr(8'h81), 8'h00);
      check("R5 unselected lines read zero", bus_rdata & 8'h7E, 8'h00);

      cur_req = "R7";
      bus_op(1'b1, 12'h400, 8'h00);
      pin_in = 8'h00;
      repeat (3) @(negedge clk);
      pin_in = 8'h5A; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = data_addr(8'hFF);
      @(negedge clk); check("R7 read at sampling edge", bus_rdata, 8'h00);
      @(negedge clk); check("R7 read one edge later", bus_rdata, 8'h00);
      @(negedge clk); check("R7 read two edges later", bus_rdata, 8'h5A);
      bus_sel = 1'b0;

      cur_req = "R8";
      pin_in = 8'hFF;
      repeat (4) @(negedge clk);
      check("R8 rdata held while idle", bus_rdata, 8'h5A);

      cur_req = "R9";
      bus_op(1'b1, 12'h400, 8'hF0);
      bus_op(1'b1, 12'h404, 8'hFF);
      bus_op(1'b1, 12'h800, 8'h00);
      check("R9 void writes keep dir", pin_oe, 8'hF0);
      bus_op(1'b0, 12'h41C, 8'h00);
      check("R9 void read zero", bus_rdata, 8'h00);

      cur_req = "R10";
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = 12'h400; bus_wdata = 8'h00;
      @(negedge clk);
      bus_wr = 1'b0;
      check("R10 unselected write ignored", pin_oe, 8'hF0);

      cur_req = "R7 mixed";
      for (int i = 0; i < 400; i++) begin
         lfsr = step(lfsr);
         pin_in = lfsr[15:8];
         case (lfsr[2:0])
            3'd0, 3'd1: bus_op(1'b1, data_addr(lfsr[10:3]), lfsr[7:0] ^ lfsr[15:8]);
            3'd2, 3'd3: bus_op(1'b0, data_addr(lfsr[11:4]), 8'h00);
            3'd4:       bus_op(1'b1, 12'h400, lfsr[13:6]);
            3'd5:       bus_op(1'b0, 12'h400 | 12'(lfsr[1:0]), 8'h00);
            3'd6:       bus_op(lfsr[3], 12'h404 + 12'({lfsr[9:4], 2'b00}), lfsr[7:0]);
            default:    @(negedge clk);
         endcase
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule